// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control sequencer for a small 16-bit multicycle RISC core. It holds a state register, reads the opcode and sub-operation fields of the instruction register, and drives the datapath with one set of control strobes per cycle. These strobes cover the program counter, the instruction register enable, the ALU operand and function selects, the register-file write and its source, and the memory read and write requests. Every instruction passes through a fixed four-state fetch and a decode state. Decode then sends it down one of six class paths. Each path ends by going back to the first fetch state.

Every output is a pure function of the current state (Moore style). The inputs `mem_done` and `alu_zero` only steer transitions. Memory requests are held until the memory answers. The sequencer has no hazard interlocks, so dependent instructions must be spaced by software.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A synchronous reset puts the sequencer in the fetch-address state. In that state only `addr_pc` is 1 and every other output is 0.
- R2: The fetch runs through four states in order:
  - the address state, with only `addr_pc` set;
  - the read-wait state, with `addr_pc` and `mem_rd` set, held until a cycle with `mem_done`=1;
  - the latch state, with only `ir_en` set;
  - the step state, with only `pc_inc` set.
  A decode state with all outputs 0 follows.
- R3: Decode selects the path from `ir_op`: 0x0 is R-type, 0x4 is load/store, 0xC is register jump, 0xB is branch, 0xE is jump-and-link, and any other value is I-type.
- R4: An R-type instruction spends one execute state with `alu_fn` taken from `ir_sub`. It then spends one write-back state with `rf_we`=1 and `wb_sel`=0 (ALU result), and then returns to fetch.
- R5: An I-type instruction spends one execute state with `b_sel_imm`=1 and `alu_fn` taken from `ir_op`. It then uses the same write-back state as R-type.
- R6: Function codes are mapped as follows. Field value 0x5 gives add (0), 0x9 gives subtract (1), 0x1 gives AND (2), 0x2 gives OR (3), 0x3 gives XOR (4), 0x8 gives shift (5), 0xD gives pass operand B (6), and any other value gives add.
- R7: For `ir_op`=0x4, a sort state (all outputs 0) follows decode. If `ir_sub` is anything other than 0x4, the instruction is a load. The load path is:
  - a request state with `mem_rd`=1;
  - a wait state with `mem_rd`=1, held until `mem_done`=1;
  - a write-back state with `rf_we`=1 and `wb_sel`=1 (memory data).
- R8: `ir_sub`=0x4 selects a store. The store path is a request state with `mem_wr`=1, then a wait state with `mem_wr`=1 held until `mem_done`=1, then fetch.
- R9: A register jump spends exactly one state with `pc_ld`=1 and `pc_from_reg`=1, then goes to fetch.
- R10: A branch spends one test state with `alu_fn`=1 (subtract) and samples `alu_zero` there.
  - If `alu_zero` is 1, a take state follows with `pc_ld`, `a_sel_pc` and `b_sel_imm` set and `alu_fn`=0.
  - If `alu_zero` is 0, fetch follows at once.
- R11: Jump-and-link spends one state with `pc_cap`, `pc_ld` and `pc_from_reg` set. It then spends one link state with `rf_we`=1 and `wb_sel`=2 (captured PC).
- R12: `mem_done` has no effect outside the fetch read-wait, load wait and store wait states. The request states, fetch address/latch states and decode all advance regardless of it.
- R13: `mem_rd` and `mem_wr` are never 1 together, and neither are `pc_ld` and `pc_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_op | input | 4 | Opcode field of the instruction register |
| ir_sub | input | 4 | Sub-operation field of the instruction register |
| mem_done | input | 1 | Memory has completed the pending request |
| alu_zero | input | 1 | ALU result is zero |
| pc_ld | output | 1 | Load the program counter |
| pc_inc | output | 1 | Increment the program counter |
| pc_from_reg | output | 1 | PC load source is a register (else ALU result) |
| pc_cap | output | 1 | Capture the current PC for linking |
| ir_en | output | 1 | Load the instruction register |
| addr_pc | output | 1 | Memory address comes from the PC |
| a_sel_pc | output | 1 | ALU operand A is the PC |
| b_sel_imm | output | 1 | ALU operand B is the immediate |
| alu_fn | output | 3 | ALU function code |
| rf_we | output | 1 | Register-file write enable |
| wb_sel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 captured PC |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |

## Verification
The hardest cases to reach are in how `mem_done` interacts with the wait states:
- a done that arrives in the very first wait cycle;
- a done held high in states that must ignore it;
- a reset that lands while a load is still waiting.

The bench reaches these cases by scheduling the inputs cycle by cycle in lockstep with the expected state sequence. This lets it raise `mem_done` in chosen non-wait states, vary the memory latency from zero to several cycles, and assert reset inside a load wait. A branch is run with `alu_zero` both high and low in its test state.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;
  localparam int OP_W = 4;
  localparam int FN_W = 3;
  localparam int WB_W = 2;

  typedef enum logic [4:0] {
    S_FETCH_ADDR, S_FETCH_WAIT, S_FETCH_LATCH, S_FETCH_STEP, S_DECODE,
    S_R_EXEC, S_I_EXEC, S_WRITEBACK,
    S_MEM_SORT, S_LD_REQ, S_LD_WAIT, S_LD_WB, S_ST_REQ, S_ST_WAIT,
    S_JUMP, S_BR_TEST, S_BR_TAKE, S_JAL_JUMP, S_JAL_LINK
  } state_t;

  typedef enum logic [2:0] {
    C_RALU, C_IALU, C_MEM, C_JUMP, C_BRANCH, C_JAL
  } iclass_t;

  localparam logic [FN_W-1:0] FN_ADD   = 3'd0;
  localparam logic [FN_W-1:0] FN_SUB   = 3'd1;
  localparam logic [FN_W-1:0] FN_AND   = 3'd2;
  localparam logic [FN_W-1:0] FN_OR    = 3'd3;
  localparam logic [FN_W-1:0] FN_XOR   = 3'd4;
  localparam logic [FN_W-1:0] FN_SHIFT = 3'd5;
  localparam logic [FN_W-1:0] FN_PASSB = 3'd6;

  localparam logic [WB_W-1:0] WB_ALU  = 2'd0;
  localparam logic [WB_W-1:0] WB_MEM  = 2'd1;
  localparam logic [WB_W-1:0] WB_LINK = 2'd2;

  typedef struct packed {
    logic            pc_ld;
    logic            pc_inc;
    logic            pc_from_reg;
    logic            pc_cap;
    logic            ir_en;
    logic            addr_pc;
    logic            a_sel_pc;
    logic            b_sel_imm;
    logic [FN_W-1:0] alu_fn;
    logic            rf_we;
    logic [WB_W-1:0] wb_sel;
    logic            mem_rd;
    logic            mem_wr;
  } ctrl_t;

  // Map an instruction code field onto the ALU function code.
  function automatic logic [FN_W-1:0] alu_fn_of(input logic [OP_W-1:0] code);
    logic [FN_W-1:0] fn;
    case (code)
      4'h5:    fn = FN_ADD;
      4'h9:    fn = FN_SUB;
      4'h1:    fn = FN_AND;
      4'h2:    fn = FN_OR;
      4'h3:    fn = FN_XOR;
      4'h8:    fn = FN_SHIFT;
      4'hD:    fn = FN_PASSB;
      default: fn = FN_ADD;
    endcase
    return fn;
  endfunction
endpackage

// File: rtl/mc_class_dec.sv
module mc_class_dec
  import mc_seq_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_RALU   = 4'h0,
  parameter logic [OP_W-1:0] OP_MEM    = 4'h4,
  parameter logic [OP_W-1:0] OP_JUMP   = 4'hC,
  parameter logic [OP_W-1:0] OP_BRANCH = 4'hB,
  parameter logic [OP_W-1:0] OP_JAL    = 4'hE,
  parameter logic [OP_W-1:0] SUB_STORE = 4'h4
) (
  input  logic [OP_W-1:0] ir_op,
  input  logic [OP_W-1:0] ir_sub,
  output iclass_t         cls,
  output logic            is_store,
  output logic [FN_W-1:0] r_fn,
  output logic [FN_W-1:0] i_fn
);
  always_comb begin
    if (ir_op == OP_RALU)        cls = C_RALU;
    else if (ir_op == OP_MEM)    cls = C_MEM;
    else if (ir_op == OP_JUMP)   cls = C_JUMP;
    else if (ir_op == OP_BRANCH) cls = C_BRANCH;
    else if (ir_op == OP_JAL)    cls = C_JAL;
    else                         cls = C_IALU;
  end

  assign is_store = (ir_sub == SUB_STORE);
  assign r_fn     = alu_fn_of(ir_sub);
  assign i_fn     = alu_fn_of(ir_op);
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_seq_pkg::*;
(
  input  state_t  cur,
  input  iclass_t cls,
  input  logic    is_store,
  input  logic    mem_done,
  input  logic    alu_zero,
  output state_t  nxt
);
  always_comb begin
    nxt = S_FETCH_ADDR;
    case (cur)
      S_FETCH_ADDR:  nxt = S_FETCH_WAIT;
      S_FETCH_WAIT:  nxt = mem_done ? S_FETCH_LATCH : S_FETCH_WAIT;
      S_FETCH_LATCH: nxt = S_FETCH_STEP;
      S_FETCH_STEP:  nxt = S_DECODE;
      S_DECODE: begin
        case (cls)
          C_RALU:   nxt = S_R_EXEC;
          C_IALU:   nxt = S_I_EXEC;
          C_MEM:    nxt = S_MEM_SORT;
          C_JUMP:   nxt = S_JUMP;
          C_BRANCH: nxt = S_BR_TEST;
          C_JAL:    nxt = S_JAL_JUMP;
          default:  nxt = S_FETCH_ADDR;
        endcase
      end
      S_R_EXEC, S_I_EXEC: nxt = S_WRITEBACK;
      S_MEM_SORT:  nxt = is_store ? S_ST_REQ : S_LD_REQ;
      S_LD_REQ:    nxt = S_LD_WAIT;
      S_LD_WAIT:   nxt = mem_done ? S_LD_WB : S_LD_WAIT;
      S_ST_REQ:    nxt = S_ST_WAIT;
      S_ST_WAIT:   nxt = mem_done ? S_FETCH_ADDR : S_ST_WAIT;
      S_BR_TEST:   nxt = alu_zero ? S_BR_TAKE : S_FETCH_ADDR;
      S_JAL_JUMP:  nxt = S_JAL_LINK;
      default:     nxt = S_FETCH_ADDR;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_seq_pkg::*;
(
  input  state_t          cur,
  input  logic [FN_W-1:0] r_fn,
  input  logic [FN_W-1:0] i_fn,
  output ctrl_t           ctl
);
  always_comb begin
    ctl = '0;
    case (cur)
      S_FETCH_ADDR:  ctl.addr_pc = 1'b1;
      S_FETCH_WAIT: begin
        ctl.addr_pc = 1'b1;
        ctl.mem_rd  = 1'b1;
      end
      S_FETCH_LATCH: ctl.ir_en  = 1'b1;
      S_FETCH_STEP:  ctl.pc_inc = 1'b1;
      S_R_EXEC:      ctl.alu_fn = r_fn;
      S_I_EXEC: begin
        ctl.alu_fn    = i_fn;
        ctl.b_sel_imm = 1'b1;
      end
      S_WRITEBACK: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_sel = WB_ALU;
      end
      S_LD_REQ, S_LD_WAIT: ctl.mem_rd = 1'b1;
      S_LD_WB: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_sel = WB_MEM;
      end
      S_ST_REQ, S_ST_WAIT: ctl.mem_wr = 1'b1;
      S_JUMP: begin
        ctl.pc_ld       = 1'b1;
        ctl.pc_from_reg = 1'b1;
      end
      S_BR_TEST: ctl.alu_fn = FN_SUB;
      S_BR_TAKE: begin
        ctl.pc_ld     = 1'b1;
        ctl.a_sel_pc  = 1'b1;
        ctl.b_sel_imm = 1'b1;
        ctl.alu_fn    = FN_ADD;
      end
      S_JAL_JUMP: begin
        ctl.pc_cap      = 1'b1;
        ctl.pc_ld       = 1'b1;
        ctl.pc_from_reg = 1'b1;
      end
      S_JAL_LINK: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_sel = WB_LINK;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_RALU   = 4'h0,
  parameter logic [OP_W-1:0] OP_MEM    = 4'h4,
  parameter logic [OP_W-1:0] OP_JUMP   = 4'hC,
  parameter logic [OP_W-1:0] OP_BRANCH = 4'hB,
  parameter logic [OP_W-1:0] OP_JAL    = 4'hE,
  parameter logic [OP_W-1:0] SUB_STORE = 4'h4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] ir_op,
  input  logic [OP_W-1:0] ir_sub,
  input  logic            mem_done,
  input  logic            alu_zero,
  output logic            pc_ld,
  output logic            pc_inc,
  output logic            pc_from_reg,
  output logic            pc_cap,
  output logic            ir_en,
  output logic            addr_pc,
  output logic            a_sel_pc,
  output logic            b_sel_imm,
  output logic [FN_W-1:0] alu_fn,
  output logic            rf_we,
  output logic [WB_W-1:0] wb_sel,
  output logic            mem_rd,
  output logic            mem_wr
);
  state_t          state_q;
  state_t          state_d;
  iclass_t         cls;
  logic            is_store;
  logic [FN_W-1:0] r_fn;
  logic [FN_W-1:0] i_fn;
  ctrl_t           ctl;

  // Named internal events for the checker.
  logic fetch_wait_evt;
  logic st_wait_evt;
  logic br_test_evt;
  logic exec_evt;

  mc_class_dec #(
    .OP_RALU(OP_RALU), .OP_MEM(OP_MEM), .OP_JUMP(OP_JUMP),
    .OP_BRANCH(OP_BRANCH), .OP_JAL(OP_JAL), .SUB_STORE(SUB_STORE)
  ) dec_i (
    .ir_op(ir_op), .ir_sub(ir_sub), .cls(cls), .is_store(is_store),
    .r_fn(r_fn), .i_fn(i_fn)
  );

  mc_next_state nxt_i (
    .cur(state_q), .cls(cls), .is_store(is_store),
    .mem_done(mem_done), .alu_zero(alu_zero), .nxt(state_d)
  );

  mc_ctrl_out out_i (
    .cur(state_q), .r_fn(r_fn), .i_fn(i_fn), .ctl(ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_FETCH_ADDR;
    else     state_q <= state_d;
  end

  assign fetch_wait_evt = (state_q == S_FETCH_WAIT);
  assign st_wait_evt    = (state_q == S_ST_WAIT);
  assign br_test_evt    = (state_q == S_BR_TEST);
  assign exec_evt       = (state_q == S_R_EXEC) || (state_q == S_I_EXEC);

  assign pc_ld       = ctl.pc_ld;
  assign pc_inc      = ctl.pc_inc;
  assign pc_from_reg = ctl.pc_from_reg;
  assign pc_cap      = ctl.pc_cap;
  assign ir_en       = ctl.ir_en;
  assign addr_pc     = ctl.addr_pc;
  assign a_sel_pc    = ctl.a_sel_pc;
  assign b_sel_imm   = ctl.b_sel_imm;
  assign alu_fn      = ctl.alu_fn;
  assign rf_we       = ctl.rf_we;
  assign wb_sel      = ctl.wb_sel;
  assign mem_rd      = ctl.mem_rd;
  assign mem_wr      = ctl.mem_wr;
endmodule

// File: rtl/mc_seq_chk.sv
module mc_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_done,
  input logic       alu_zero,
  input logic       pc_ld,
  input logic       pc_inc,
  input logic       pc_cap,
  input logic       ir_en,
  input logic       addr_pc,
  input logic       a_sel_pc,
  input logic       rf_we,
  input logic [1:0] wb_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       fetch_wait_evt,
  input logic       st_wait_evt,
  input logic       br_test_evt,
  input logic       exec_evt
);
  // R1: reset lands in the fetch-address state
  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (addr_pc && !mem_rd && !mem_wr && !rf_we && !pc_ld && !ir_en));

  // R2: read request held while memory has not answered
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_done) |=> mem_rd);

  // R2: done in the fetch wait moves on to latching the instruction
  a_r2_fetch_done: assert property (@(posedge clk) disable iff (rst)
    (fetch_wait_evt && mem_done) |=> (ir_en && !mem_rd));

  // R8: write request held, then dropped after done
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_done) |=> mem_wr);
  a_r8_wr_drop: assert property (@(posedge clk) disable iff (rst)
    (st_wait_evt && mem_done) |=> (!mem_wr && addr_pc));

  // R4: execute is followed by an ALU write-back
  a_r4_exec_wb: assert property (@(posedge clk) disable iff (rst)
    exec_evt |=> (rf_we && wb_sel == 2'd0));

  // R10: branch outcome follows the zero flag
  a_r10_taken: assert property (@(posedge clk) disable iff (rst)
    (br_test_evt && alu_zero) |=> (pc_ld && a_sel_pc));
  a_r10_not_taken: assert property (@(posedge clk) disable iff (rst)
    (br_test_evt && !alu_zero) |=> (addr_pc && !pc_ld));

  // R11: captured PC is written back in the next state
  a_r11_link: assert property (@(posedge clk) disable iff (rst)
    pc_cap |=> (rf_we && wb_sel == 2'd2));

  // R13: mutually exclusive strobes
  a_r13_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr) && !(pc_ld && pc_inc));
endmodule

bind mc_seq_ctrl mc_seq_chk chk_i (
  .clk(clk), .rst(rst), .mem_done(mem_done), .alu_zero(alu_zero),
  .pc_ld(pc_ld), .pc_inc(pc_inc), .pc_cap(pc_cap), .ir_en(ir_en),
  .addr_pc(addr_pc), .a_sel_pc(a_sel_pc), .rf_we(rf_we), .wb_sel(wb_sel),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .fetch_wait_evt(fetch_wait_evt),
  .st_wait_evt(st_wait_evt), .br_test_evt(br_test_evt), .exec_evt(exec_evt)
);

// File: tb/mc_seq_ctrl_tb_top.sv
module mc_seq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] ir_op, ir_sub;
  logic       mem_done, alu_zero;
  logic       pc_ld, pc_inc, pc_from_reg, pc_cap, ir_en, addr_pc;
  logic       a_sel_pc, b_sel_imm, rf_we, mem_rd, mem_wr;
  logic [2:0] alu_fn;
  logic [1:0] wb_sel;

  always #10 clk = ~clk;  // 50 MHz

  mc_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .ir_op(ir_op), .ir_sub(ir_sub),
    .mem_done(mem_done), .alu_zero(alu_zero), .pc_ld(pc_ld), .pc_inc(pc_inc),
    .pc_from_reg(pc_from_reg), .pc_cap(pc_cap), .ir_en(ir_en),
    .addr_pc(addr_pc), .a_sel_pc(a_sel_pc), .b_sel_imm(b_sel_imm),
    .alu_fn(alu_fn), .rf_we(rf_we), .wb_sel(wb_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  // Observed control word: bit15 pc_ld .. bit0 mem_wr
  logic [15:0] obs;
  assign obs = {pc_ld, pc_inc, pc_from_reg, pc_cap, ir_en, addr_pc, a_sel_pc,
                b_sel_imm, alu_fn, rf_we, wb_sel, mem_rd, mem_wr};

  localparam logic [15:0] W_F0 = 16'h0400, W_F1 = 16'h0402, W_F2 = 16'h0800,
                          W_F3 = 16'h4000, W_IDLE = 16'h0000,
                          W_WB_ALU = 16'h0010, W_RD = 16'h0002,
                          W_LD_WB = 16'h0014, W_WR = 16'h0001,
                          W_JUMP = 16'hA000, W_BR_TEST = 16'h0020,
                          W_BR_TAKE = 16'h8300, W_JAL_J = 16'hB000,
                          W_JAL_L = 16'h0018, W_IMM = 16'h0100;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;
  bit wd  = 1'b0;

  // Independent restatement of the function-code table (R6)
  function automatic logic [15:0] fn_word(input logic [3:0] c);
    logic [2:0] f;
    f = 3'd0;
    if (c == 4'h9) f = 3'd1;
    if (c == 4'h1) f = 3'd2;
    if (c == 4'h2) f = 3'd3;
    if (c == 4'h3) f = 3'd4;
    if (c == 4'h8) f = 3'd5;
    if (c == 4'hD) f = 3'd6;
    return {8'h00, f, 5'b00000};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, e);
    end
  endtask

  // Driver: entered at posedge+2; sets inputs for this cycle, queues expectation.
  task automatic step(input logic [15:0] e, input logic d, input logic z,
                      input logic r, input string t);
    mem_done = d; alu_zero = z; rst = r;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #2;
  endtask

  // Monitor: pops one expectation per cycle, sampled at posedge+5.
  initial begin
    forever begin
      @(posedge clk); #5;
      if (exp_q.size() > 0) chk(tag_q.pop_front(), obs, exp_q.pop_front());
    end
  end

  task automatic fetch(input logic [3:0] op, input logic [3:0] sub, input int lat);
    step(W_F0, 1'b1, 1'b0, 1'b0, "R2 R12 fetch addr ignores done");
    for (int i = 0; i < lat; i++) step(W_F1, 1'b0, 1'b0, 1'b0, "R2 fetch wait held");
    step(W_F1, 1'b1, 1'b0, 1'b0, "R2 fetch wait done");
    ir_op = op; ir_sub = sub;
    step(W_F2, 1'b1, 1'b0, 1'b0, "R2 R12 latch");
    step(W_F3, 1'b0, 1'b0, 1'b0, "R2 pc step");
    step(W_IDLE, 1'b1, 1'b0, 1'b0, "R3 R12 decode");
  endtask

  task automatic r_type(input logic [3:0] sub, input int lat);
    fetch(4'h0, sub, lat);
    step(fn_word(sub), 1'b0, 1'b0, 1'b0, "R4 R6 r exec");
    step(W_WB_ALU, 1'b0, 1'b0, 1'b0, "R4 r writeback");
  endtask

  task automatic i_type(input logic [3:0] op);
    fetch(op, 4'hF, 1);
    step(fn_word(op) | W_IMM, 1'b0, 1'b0, 1'b0, "R5 R6 i exec");
    step(W_WB_ALU, 1'b0, 1'b0, 1'b0, "R5 i writeback");
  endtask

  task automatic load_op(input logic [3:0] sub, input int lat);
    fetch(4'h4, sub, 1);
    step(W_IDLE, 1'b1, 1'b0, 1'b0, "R7 sort");
    step(W_RD, 1'b1, 1'b0, 1'b0, "R7 R12 load req");
    for (int i = 0; i < lat; i++) step(W_RD, 1'b0, 1'b0, 1'b0, "R7 load wait held");
    step(W_RD, 1'b1, 1'b0, 1'b0, "R7 load wait done");
    step(W_LD_WB, 1'b0, 1'b0, 1'b0, "R7 load writeback");
  endtask

  task automatic store_op(input int lat);
    fetch(4'h4, 4'h4, 2);
    step(W_IDLE, 1'b0, 1'b0, 1'b0, "R8 sort");
    step(W_WR, 1'b1, 1'b0, 1'b0, "R8 R12 store req");
    for (int i = 0; i < lat; i++) step(W_WR, 1'b0, 1'b0, 1'b0, "R8 store wait held");
    step(W_WR, 1'b1, 1'b0, 1'b0, "R8 store wait done");
  endtask

  initial begin
    rst = 1'b1; ir_op = 4'h0; ir_sub = 4'h0; mem_done = 1'b0; alu_zero = 1'b0;
    repeat (3) @(posedge clk);
    #5 chk("R1 reset state", obs, W_F0);
    @(posedge clk); #2;

    r_type(4'h1, 0);            // AND, zero-latency fetch
    r_type(4'h7, 3);            // unmapped sub-op -> add
    r_type(4'h9, 1);            // SUB
    i_type(4'h5);               // ADDI
    i_type(4'hD);               // move immediate -> pass B
    i_type(4'h8);               // shift
    i_type(4'h3);               // XORI
    i_type(4'h2);               // ORI
    load_op(4'h0, 3);
    load_op(4'h9, 0);           // any non-store sub-op is a load
    store_op(2);
    store_op(0);
    fetch(4'hC, 4'h0, 1);
    step(W_JUMP, 1'b1, 1'b0, 1'b0, "R9 jump");
    fetch(4'hB, 4'h0, 1);
    step(W_BR_TEST, 1'b0, 1'b1, 1'b0, "R10 branch test taken");
    step(W_BR_TAKE, 1'b0, 1'b0, 1'b0, "R10 branch take");
    fetch(4'hB, 4'h0, 0);
    step(W_BR_TEST, 1'b0, 1'b0, 1'b0, "R10 branch test not taken");
    fetch(4'hE, 4'h0, 1);
    step(W_JAL_J, 1'b0, 1'b0, 1'b0, "R11 jal jump");
    step(W_JAL_L, 1'b0, 1'b0, 1'b0, "R11 jal link");

    // R1: reset while a load is waiting
    fetch(4'h4, 4'h0, 1);
    step(W_IDLE, 1'b0, 1'b0, 1'b0, "R7 sort");
    step(W_RD, 1'b0, 1'b0, 1'b0, "R7 load req");
    step(W_RD, 1'b0, 1'b0, 1'b1, "R1 load wait under reset");
    step(W_F0, 1'b0, 1'b0, 1'b0, "R1 reset mid-load to fetch");
    step(W_F1, 1'b1, 1'b0, 1'b0, "R2 fetch after reset");
    step(W_F2, 1'b0, 1'b0, 1'b0, "R2 latch after reset");

    repeat (3) @(posedge clk);
    fin = 1'b1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    wd = 1'b1;
  end

  initial begin
    wait (fin || wd);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule